// File: doc/BRIEF.md
# Multiplexed Result Byte Port

This block connects a 12-bit conversion result to an 8-bit host bus. The host selects the port with an active-low chip select. A read strobe puts one byte of the result on the data pins, and a write strobe loads a control byte from the same pins. A lane-select input chooses which byte is read:

- the low lane carries the eight least significant result bits;
- the high lane carries the top four result bits in its low nibble.

The upper nibble of the high lane is filled according to the polarity of the stored result. In bipolar (two's complement) mode it repeats the sign bit. In unipolar (straight binary) mode it is zero.

The pins are split into an input bus, an output bus and an output enable, so that the pad ring builds the three-state buffer. A result is accepted with a one-cycle valid pulse, together with the polarity flag that applies to it.

The block holds the result steady for as long as a read strobe is active. It also tells the sequencer, with a one-cycle pulse, when a fresh result has been read for the first time, so that the sequencer can clear its interrupt.

Top module: `res_byte_port`

## Requirements
- R1: With lane select low (0), `data_o[7:0]` equals stored result bits 7..0, bit 0 being the LSB.
- R2: With lane select high (1), `data_o[3:0]` equals stored result bits 11..8, bit 11 being the MSB.
- R3: With lane select high, `data_o[7:4]` are all copies of result bit 11 when the stored polarity flag is 1, and all zero when it is 0. The flag is captured with the result on `result_valid_i`; later changes of `bipolar_i` have no effect.
- R4: `data_oe_o` is 1 exactly while `cs_ni` and `rd_ni` are both 0, so it stays 0 throughout a write cycle.
- R5: On the first clock edge that sees `wr_ni` high after a low sample, with `cs_ni` low at that low sample, the byte sampled from `data_i` is loaded into `ctrl_o`, and `ctrl_we_o` pulses for one cycle. A write strobe while `cs_ni` is high changes nothing.
- R6: `rd_done_o` pulses for one cycle at the end of the first completed read after a new result becomes visible. Later reads of the same result give no pulse.
- R7: A read strobe while `cs_ni` is high neither drives the bus nor counts as a read.
- R8: The visible result changes only when a result arrives. A result that arrives while a read is active is held back and becomes visible on the first clock edge with no active read.
- R9: After reset the output enable, `ctrl_o`, `ctrl_we_o` and `rd_done_o` are 0, and the stored result reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| result_i | input | 12 | Conversion result from the engine |
| result_valid_i | input | 1 | One-cycle pulse: result_i and bipolar_i are valid |
| bipolar_i | input | 1 | Polarity of the arriving result (1 = two's complement) |
| cs_ni | input | 1 | Chip select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| byte_sel_i | input | 1 | Lane select: 0 low byte, 1 high byte |
| data_i | input | 8 | Data pins, inbound |
| data_o | output | 8 | Data pins, outbound |
| data_oe_o | output | 1 | Pad output enable |
| ctrl_o | output | 8 | Last control byte written |
| ctrl_we_o | output | 1 | One-cycle pulse when ctrl_o is loaded |
| rd_done_o | output | 1 | One-cycle pulse on the first read of a new result |

## Verification
The bench targets the following corner cases:

- **Sign fill of the high lane.** It reads a negative bipolar code, a full-scale unipolar code and the most negative code. A design that took the fill from the wrong bit, or ignored polarity, returns 0x0F where 0xFF is due, or the reverse.
- **Polarity latched with the result.** It flips `bipolar_i` after the result has been stored. A design that used the live pin would change the high lane.
- **Read done only once.** It reads the same result twice and checks that a second pulse is absent. A design that pulsed on every read would clear the interrupt for a stale result.
- **Deselected strobes.** It issues read and write strobes with `cs_ni` high. A design that did not gate them by chip select would drive the bus, report a read or overwrite `ctrl_o`.
- **Result arriving mid-read.** It delivers a result during an active read. A design that loaded it at once would change the byte under the host; one that lost it would never show the new value.

// File: rtl/res_byte_port_pkg.sv
`timescale 1ns/1ps
package res_byte_port_pkg;
  parameter int unsigned RES_W_DEF = 12;
  parameter int unsigned BUS_W_DEF = 8;

  typedef enum logic {
    LANE_LO = 1'b0,
    LANE_HI = 1'b1
  } lane_e;
endpackage

// File: rtl/rbp_strobe_sync.sv
`timescale 1ns/1ps
module rbp_strobe_sync #(
  parameter int unsigned BUS_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             rd_ni,
  input  logic             wr_ni,
  input  logic [BUS_W-1:0] data_i,
  output logic             rd_end_o,
  output logic             wr_end_o,
  output logic [BUS_W-1:0] wr_byte_o
);
  logic             cs_q, rd_q, wr_q;
  logic [BUS_W-1:0] d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q <= 1'b1;
      rd_q <= 1'b1;
      wr_q <= 1'b1;
      d_q  <= '0;
    end else begin
      cs_q <= cs_ni;
      rd_q <= rd_ni;
      wr_q <= wr_ni;
      d_q  <= data_i;
    end
  end

  // cycle end = strobe was low under chip select, now released
  assign rd_end_o  = !cs_q && !rd_q && rd_ni;
  assign wr_end_o  = !cs_q && !wr_q && wr_ni;
  assign wr_byte_o = d_q;

  // R6
  rd_end_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_end_o |=> !rd_end_o);
endmodule

// File: rtl/rbp_result_store.sv
`timescale 1ns/1ps
module rbp_result_store #(
  parameter int unsigned RES_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [RES_W-1:0] code_i,
  input  logic             bip_i,
  input  logic             hold_i,
  input  logic             rd_end_i,
  output logic [RES_W-1:0] code_o,
  output logic             bip_o,
  output logic             rd_done_o
);
  logic [RES_W-1:0] vis_code_q, shd_code_q, src_code;
  logic             vis_bip_q, shd_bip_q, shd_vld_q, src_bip;
  logic             avail_q, done_q, commit;

  assign commit   = !hold_i && (load_i || shd_vld_q);
  assign src_code = load_i ? code_i : shd_code_q;
  assign src_bip  = load_i ? bip_i  : shd_bip_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vis_code_q <= '0;
      vis_bip_q  <= 1'b0;
      shd_code_q <= '0;
      shd_bip_q  <= 1'b0;
      shd_vld_q  <= 1'b0;
      avail_q    <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      if (load_i && hold_i) begin
        shd_code_q <= code_i;
        shd_bip_q  <= bip_i;
        shd_vld_q  <= 1'b1;
      end else if (commit) begin
        shd_vld_q  <= 1'b0;
      end
      if (commit) begin
        vis_code_q <= src_code;
        vis_bip_q  <= src_bip;
      end
      done_q <= rd_end_i && avail_q;
      if (commit)        avail_q <= 1'b1;
      else if (rd_end_i) avail_q <= 1'b0;
    end
  end

  assign code_o    = vis_code_q;
  assign bip_o     = vis_bip_q;
  assign rd_done_o = done_q;

  // R8
  hold_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(hold_i) |-> ($stable(vis_code_q) && $stable(vis_bip_q)));
  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_done_o |=> !rd_done_o);
  // R6
  done_needs_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_done_o |-> $past(avail_q));
endmodule

// File: rtl/rbp_byte_mux.sv
`timescale 1ns/1ps
module rbp_byte_mux
  import res_byte_port_pkg::*;
#(
  parameter int unsigned RES_W = 12,
  parameter int unsigned BUS_W = 8
) (
  input  logic [RES_W-1:0] code_i,
  input  logic             bip_i,
  input  logic             sel_i,
  output logic [BUS_W-1:0] byte_o
);
  localparam int unsigned HI_W = RES_W - BUS_W;

  logic [BUS_W-1:0] lo_byte, hi_byte;
  logic             fill;

  assign lo_byte = code_i[BUS_W-1:0];
  assign fill    = bip_i & code_i[RES_W-1];

  for (genvar i = 0; i < BUS_W; i++) begin : g_hi
    if (i < HI_W) begin : g_bit
      assign hi_byte[i] = code_i[BUS_W+i];
    end else begin : g_ext
      assign hi_byte[i] = fill;
    end
  end

  assign byte_o = (lane_e'(sel_i) == LANE_HI) ? hi_byte : lo_byte;
endmodule

// File: rtl/res_byte_port.sv
`timescale 1ns/1ps
module res_byte_port
  import res_byte_port_pkg::*;
#(
  parameter int unsigned RES_W = RES_W_DEF,
  parameter int unsigned BUS_W = BUS_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [RES_W-1:0] result_i,
  input  logic             result_valid_i,
  input  logic             bipolar_i,
  input  logic             cs_ni,
  input  logic             rd_ni,
  input  logic             wr_ni,
  input  logic             byte_sel_i,
  input  logic [BUS_W-1:0] data_i,
  output logic [BUS_W-1:0] data_o,
  output logic             data_oe_o,
  output logic [BUS_W-1:0] ctrl_o,
  output logic             ctrl_we_o,
  output logic             rd_done_o
);
  logic             rd_end, wr_end, rd_active;
  logic [BUS_W-1:0] wr_byte, ctrl_q;
  logic             we_q, vis_bip;
  logic [RES_W-1:0] vis_code;

  assign rd_active = !cs_ni && !rd_ni;

  rbp_strobe_sync #(.BUS_W(BUS_W)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_ni    (cs_ni),
    .rd_ni    (rd_ni),
    .wr_ni    (wr_ni),
    .data_i   (data_i),
    .rd_end_o (rd_end),
    .wr_end_o (wr_end),
    .wr_byte_o(wr_byte)
  );

  rbp_result_store #(.RES_W(RES_W)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (result_valid_i),
    .code_i   (result_i),
    .bip_i    (bipolar_i),
    .hold_i   (rd_active),
    .rd_end_i (rd_end),
    .code_o   (vis_code),
    .bip_o    (vis_bip),
    .rd_done_o(rd_done_o)
  );

  rbp_byte_mux #(.RES_W(RES_W), .BUS_W(BUS_W)) u_mux (
    .code_i(vis_code),
    .bip_i (vis_bip),
    .sel_i (byte_sel_i),
    .byte_o(data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      we_q   <= 1'b0;
    end else begin
      we_q <= wr_end;
      if (wr_end) ctrl_q <= wr_byte;
    end
  end

  assign data_oe_o = rd_active;
  assign ctrl_o    = ctrl_q;
  assign ctrl_we_o = we_q;

  // R7
  no_drive_deselected_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> !data_oe_o);
  // R4
  no_drive_in_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_ni && rd_ni) |-> !data_oe_o);
  // R5
  ctrl_we_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_o |=> !ctrl_we_o);
  // R5
  ctrl_only_on_we_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ctrl_q) |-> ctrl_we_o);
  // R3
  sign_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_sel_i |-> (data_o[BUS_W-1] == (vis_bip & vis_code[RES_W-1])));
endmodule

// File: tb/res_byte_port_tb_top.sv
`timescale 1ns/1ps
module res_byte_port_tb_top;
  localparam int WATCHDOG_CYC = 20000;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic [11:0] result_i;
  logic        result_valid_i, bipolar_i;
  logic        cs_ni, rd_ni, wr_ni, byte_sel_i;
  logic [7:0]  data_i, data_o, ctrl_o;
  logic        data_oe_o, ctrl_we_o, rd_done_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  typedef struct {
    string      tag;
    logic [7:0] exp;
  } item_t;
  item_t exp_q[$];
  event  mon_ev;

  always #2.5 clk = ~clk;

  res_byte_port dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .result_i(result_i),
    .result_valid_i(result_valid_i), .bipolar_i(bipolar_i),
    .cs_ni(cs_ni), .rd_ni(rd_ni), .wr_ni(wr_ni), .byte_sel_i(byte_sel_i),
    .data_i(data_i), .data_o(data_o), .data_oe_o(data_oe_o),
    .ctrl_o(ctrl_o), .ctrl_we_o(ctrl_we_o), .rd_done_o(rd_done_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      item_t it;
      @(mon_ev);
      while (exp_q.size() > 0) begin
        it = exp_q.pop_front();
        chk(it.tag, {24'h0, data_o}, {24'h0, it.exp});
      end
    end
  end

  task automatic push_exp(input string tag, input logic [7:0] exp);
    exp_q.push_back('{tag: tag, exp: exp});
    ->mon_ev;
    #0.1;
  endtask

  task automatic load(input logic [11:0] v, input logic b);
    @(negedge clk);
    result_i = v; bipolar_i = b; result_valid_i = 1'b1;
    @(negedge clk);
    result_valid_i = 1'b0;
  endtask

  task automatic do_read(input logic sel, input logic [7:0] exp, input string tag,
                         output logic done);
    @(negedge clk);
    cs_ni = 1'b0; rd_ni = 1'b0; byte_sel_i = sel;
    #1;
    push_exp(tag, exp);
    chk("R4 oe during read", {31'h0, data_oe_o}, 32'h1);
    @(posedge clk);
    @(negedge clk);
    rd_ni = 1'b1; cs_ni = 1'b1;
    @(posedge clk);
    @(negedge clk);
    done = rd_done_o;
    @(negedge clk);
    chk("R6 done pulse width", {31'h0, rd_done_o}, 32'h0);
  endtask

  task automatic do_write(input logic cs_v, input logic [7:0] d, output logic we);
    @(negedge clk);
    cs_ni = cs_v; wr_ni = 1'b0; data_i = d;
    #1;
    chk("R4 no drive in write", {31'h0, data_oe_o}, 32'h0);
    @(posedge clk);
    @(negedge clk);
    wr_ni = 1'b1; cs_ni = 1'b1;
    @(posedge clk);
    @(negedge clk);
    we = ctrl_we_o;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(WATCHDOG_CYC * 5.0);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic d, we;
    rst_ni = 1'b0; result_i = '0; result_valid_i = 1'b0; bipolar_i = 1'b0;
    cs_ni = 1'b1; rd_ni = 1'b1; wr_ni = 1'b1; byte_sel_i = 1'b0; data_i = '0;
    repeat (3) @(negedge clk);
    chk("R9 oe reset", {31'h0, data_oe_o}, 0);
    chk("R9 ctrl reset", {24'h0, ctrl_o}, 0);
    chk("R9 we reset", {31'h0, ctrl_we_o}, 0);
    chk("R9 done reset", {31'h0, rd_done_o}, 0);
    chk("R9 data reset", {24'h0, data_o}, 0);
    rst_ni = 1'b1;

    // bipolar negative
    load(12'h9C3, 1'b1);
    do_read(1'b0, 8'hC3, "R1 low lane 9C3", d);
    chk("R6 first read done", {31'h0, d}, 1);
    do_read(1'b1, 8'hF9, "R3 high lane sign fill 9C3", d);
    chk("R6 second read no done", {31'h0, d}, 0);
    bipolar_i = 1'b0;
    do_read(1'b1, 8'hF9, "R3 polarity latched", d);

    // bipolar positive
    load(12'h5A7, 1'b1);
    do_read(1'b1, 8'h05, "R2 high lane 5A7", d);
    chk("R6 new result done", {31'h0, d}, 1);
    do_read(1'b0, 8'hA7, "R1 low lane 5A7", d);

    // unipolar full scale
    load(12'hFFF, 1'b0);
    do_read(1'b1, 8'h0F, "R3 unipolar zero fill", d);
    do_read(1'b0, 8'hFF, "R1 low lane FFF", d);

    // most negative
    load(12'h800, 1'b1);
    do_read(1'b1, 8'hF8, "R3 most negative", d);

    // deselected read
    load(12'h123, 1'b0);
    @(negedge clk);
    cs_ni = 1'b1; rd_ni = 1'b0;
    #1;
    chk("R7 no drive deselected", {31'h0, data_oe_o}, 0);
    @(posedge clk); @(negedge clk);
    rd_ni = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R7 no done deselected", {31'h0, rd_done_o}, 0);
    do_read(1'b0, 8'h23, "R1 low lane 123", d);
    chk("R7 result still unread", {31'h0, d}, 1);

    // control writes
    do_write(1'b0, 8'hA5, we);
    chk("R5 we pulse", {31'h0, we}, 1);
    chk("R5 ctrl captured", {24'h0, ctrl_o}, 32'hA5);
    @(negedge clk);
    chk("R5 we one cycle", {31'h0, ctrl_we_o}, 0);
    do_write(1'b1, 8'h3C, we);
    chk("R5 deselected write no we", {31'h0, we}, 0);
    chk("R5 deselected write ignored", {24'h0, ctrl_o}, 32'hA5);

    // result arriving mid-read
    @(negedge clk);
    cs_ni = 1'b0; rd_ni = 1'b0; byte_sel_i = 1'b0;
    #1;
    push_exp("R8 before arrival", 8'h23);
    @(negedge clk);
    result_i = 12'h456; bipolar_i = 1'b0; result_valid_i = 1'b1;
    @(negedge clk);
    result_valid_i = 1'b0;
    #1;
    push_exp("R8 held during read", 8'h23);
    @(negedge clk);
    rd_ni = 1'b1; cs_ni = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R8 old result read no done", {31'h0, rd_done_o}, 0);
    do_read(1'b0, 8'h56, "R8 deferred result visible", d);
    chk("R8 deferred result done", {31'h0, d}, 1);
    do_read(1'b1, 8'h04, "R2 high lane 456", d);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule